// File: doc/BRIEF.md
# Test pattern colour generator

This block turns the pixel position and active-video flag of a raster timing generator into a packed RGB word for a resistor-ladder video DAC. A two-bit pattern select picks one of four fixed images: eight-colour vertical bars, a checkerboard, diagonal lines, or a plain white field. Every image comes from bit slices of the horizontal and vertical counts. No pixel memory is involved.

One register stage sits between the counts and the colour output. Horizontal and vertical sync go through a matching one-cycle delay, so each pixel stays aligned with its sync pulses at the connector. Outside active video the colour word is forced to zero, which is black. A parameter selects either a 12-bit word with 4/4/4 bits or an 8-bit word with 3/3/2 bits per channel.

Top module: `pattern_colour_gen`

## Requirements
- R1: While `rst_n` is low at a clock edge, the colour output is cleared to zero after that edge, and both sync outputs are set to 1, the idle level of a negative-going pulse.
- R2: With `NARROW`=0 the colour word is 12 bits wide. Red is in bits [11:8], green in [7:4] and blue in [3:0]. Each channel field is either all ones or all zeros, so all bits set is white and zero is black.
- R3: With `NARROW`=1 the colour word is 8 bits wide. Red is in bits [7:5], green in [4:2] and blue in [1:0]. Each field is either all ones or all zeros.
- R4: When `active` is low, the colour output after the next edge is zero, whatever the mode and counts.
- R5: The colour output at any cycle reflects the inputs sampled at the preceding clock edge, which is exactly one register stage.
- R6: `hsync_out` and `vsync_out` equal `hsync_in` and `vsync_in` as sampled at the preceding clock edge.
- R7: Mode 0 draws vertical bars 64 pixels wide. Count bits hcount[8:6] select the colour: bit 8 lights red, bit 7 lights green and bit 6 lights blue.
- R8: Mode 1 draws a checkerboard of 32x32 cells. A pixel is white where hcount[5] XOR vcount[5] is 1, and black otherwise.
- R9: Mode 2 draws diagonals. A pixel is white where the low five bits of (hcount - vcount) are zero, and black otherwise.
- R10: Mode 3 draws a white field across all of active video.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| hcount | input | HCW | Pixel position within the line |
| vcount | input | VCW | Line position within the frame |
| active | input | 1 | High during visible pixels |
| mode | input | 2 | Pattern select: 0 bars, 1 checkerboard, 2 diagonals, 3 white |
| hsync_in | input | 1 | Horizontal sync from the timing generator |
| vsync_in | input | 1 | Vertical sync from the timing generator |
| rgb | output | CW | Packed colour, 12 or 8 bits |
| hsync_out | output | 1 | Horizontal sync delayed by one cycle |
| vsync_out | output | 1 | Vertical sync delayed by one cycle |

## Verification
The bench sweeps all four modes over whole 800-pixel lines. It uses lines on either side of the 32-line and 64-line boundaries, plus the first blank line below the picture. Both packings are driven side by side.

- **Off-by-one slice:** a design that takes the wrong count bit would move the bar or cell edges by a factor of two.
- **Diagonal wrap:** a diagonal test that ignores the subtraction wrap would drop the lines to the left of the main diagonal.
- **Missing delay:** a design that omits the sync delay, or registers the colour twice, would shift the picture one pixel against sync. The per-cycle comparison catches that shift.
- **Leaky blanking:** blanking that leaks would show colour in the porches or on the blank lines.
- **Swapped fields:** a swapped packing would paint red where blue belongs.

// File: rtl/pattern_colour_gen.sv
module pattern_colour_gen #(
  parameter int HCW    = 10,
  parameter int VCW    = 10,
  parameter bit NARROW = 1'b0,
  localparam int RW = NARROW ? 3 : 4,
  localparam int GW = NARROW ? 3 : 4,
  localparam int BW = NARROW ? 2 : 4,
  localparam int CW = RW + GW + BW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [HCW-1:0] hcount,
  input  logic [VCW-1:0] vcount,
  input  logic           active,
  input  logic [1:0]     mode,
  input  logic           hsync_in,
  input  logic           vsync_in,
  output logic [CW-1:0]  rgb,
  output logic           hsync_out,
  output logic           vsync_out
);

  logic [HCW-1:0] diff;
  logic [2:0]     lit;
  logic [CW-1:0]  rgb_nxt;

  assign diff = hcount - HCW'(vcount);

  always_comb begin
    case (mode)
      2'd0:    lit = hcount[8:6];
      2'd1:    lit = {3{hcount[5] ^ vcount[5]}};
      2'd2:    lit = {3{diff[4:0] == 5'd0}};
      default: lit = 3'b111;
    endcase
  end

  assign rgb_nxt = active ? {{RW{lit[2]}}, {GW{lit[1]}}, {BW{lit[0]}}} : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rgb       <= '0;
      hsync_out <= 1'b1;
      vsync_out <= 1'b1;
    end else begin
      rgb       <= rgb_nxt;
      hsync_out <= hsync_in;
      vsync_out <= vsync_in;
    end
  end

endmodule

module pattern_colour_gen_chk #(
  parameter int HCW    = 10,
  parameter int VCW    = 10,
  parameter bit NARROW = 1'b0,
  parameter int CW     = 12
) (
  input logic           clk,
  input logic           rst_n,
  input logic [HCW-1:0] hcount,
  input logic [VCW-1:0] vcount,
  input logic           active,
  input logic [1:0]     mode,
  input logic           hsync_in,
  input logic           vsync_in,
  input logic [CW-1:0]  rgb,
  input logic           hsync_out,
  input logic           vsync_out
);
  localparam int RW = NARROW ? 3 : 4;
  localparam int BW = NARROW ? 2 : 4;

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |=> (rgb == '0) && hsync_out && vsync_out);

  // R4
  blank_black_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> rgb == '0);

  // R6
  sync_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (hsync_out == $past(hsync_in)) && (vsync_out == $past(vsync_in)));

  // R2 R3
  field_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((&rgb[CW-1 -: RW]) || !(|rgb[CW-1 -: RW])) &&
    ((&rgb[BW-1:0]) || !(|rgb[BW-1:0])));

  // R8
  checker_cell_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && mode == 2'd1) |=> rgb == {CW{$past(hcount[5] ^ vcount[5])}});

  // R10
  white_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && mode == 2'd3) |=> &rgb);
endmodule

bind pattern_colour_gen pattern_colour_gen_chk #(
  .HCW(HCW), .VCW(VCW), .NARROW(NARROW), .CW(CW)
) chk_i (.*);

// File: tb/pattern_colour_gen_tb.sv
module pattern_colour_gen_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [9:0] hcount, vcount;
  logic       active, hsync_in, vsync_in;
  logic [1:0] mode;
  logic [11:0] rgb_w;
  logic [7:0]  rgb_n;
  logic hs_w, vs_w, hs_n, vs_n;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  pattern_colour_gen #(.NARROW(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n), .hcount(hcount), .vcount(vcount), .active(active),
    .mode(mode), .hsync_in(hsync_in), .vsync_in(vsync_in),
    .rgb(rgb_w), .hsync_out(hs_w), .vsync_out(vs_w));

  pattern_colour_gen #(.NARROW(1'b1)) dut_n (
    .clk(clk), .rst_n(rst_n), .hcount(hcount), .vcount(vcount), .active(active),
    .mode(mode), .hsync_in(hsync_in), .vsync_in(vsync_in),
    .rgb(rgb_n), .hsync_out(hs_n), .vsync_out(vs_n));

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int pat(int m, int h, int v);
    case (m)
      0: return (h / 64) % 8;
      1: return (((h / 32) + (v / 32)) % 2) ? 7 : 0;
      2: return ((h % 32) == (v % 32)) ? 7 : 0;
      default: return 7;
    endcase
  endfunction

  function automatic int pack_w(int bits, int act);
    if (act == 0) return 0;
    return ((bits & 4) ? 12'hF00 : 0) + ((bits & 2) ? 12'h0F0 : 0) + ((bits & 1) ? 12'h00F : 0);
  endfunction

  function automatic int pack_n(int bits, int act);
    if (act == 0) return 0;
    return ((bits & 4) ? 8'hE0 : 0) + ((bits & 2) ? 8'h1C : 0) + ((bits & 1) ? 8'h03 : 0);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int vlist[9] = '{0, 31, 32, 33, 63, 64, 100, 479, 480};
    int ph, pv, pm, pa, phs, pvs, bits;
    bit have;
    string tg;
    rst_n = 1'b0; hcount = 10'd0; vcount = 10'd0; active = 1'b1;
    mode = 2'd3; hsync_in = 1'b0; vsync_in = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 rgb wide", rgb_w, 0);
    chk("R1 rgb narrow", rgb_n, 0);
    chk("R1 hsync", hs_w, 1);
    chk("R1 vsync", vs_n, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 R2 white wide", rgb_w, 12'hFFF);
    chk("R10 R3 white narrow", rgb_n, 8'hFF);
    chk("R6 hsync after reset", hs_w, 0);

    have = 1'b0;
    for (int m = 0; m < 4; m++) begin
      for (int vi = 0; vi < 9; vi++) begin
        for (int h = 0; h < 800; h++) begin
          @(negedge clk);
          if (have) begin
            bits = pat(pm, ph, pv);
            if (pa == 0) tg = "R4 blank";
            else case (pm)
              0: tg = "R7 R2 R5 bars";
              1: tg = "R8 R2 R5 checker";
              2: tg = "R9 R2 R5 diagonal";
              default: tg = "R10 R2 R5 white";
            endcase
            chk(tg, rgb_w, pack_w(bits, pa));
            chk("R3 narrow packing", rgb_n, pack_n(bits, pa));
            chk("R6 hsync delay", hs_w, phs);
            chk("R6 vsync delay", vs_n, pvs);
          end
          hcount = 10'(h);
          vcount = 10'(vlist[vi]);
          mode = 2'(m);
          active = (h < 640) && (vlist[vi] < 480);
          hsync_in = !(h >= 656 && h < 752);
          vsync_in = !(vlist[vi] == 480);
          ph = h; pv = vlist[vi]; pm = m; pa = int'(active);
          phs = int'(hsync_in); pvs = int'(vsync_in);
          have = 1'b1;
        end
      end
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule